// File: doc/BRIEF.md
# S-Interface Multiframe Sync Counter

This block keeps the frame position of a basic-rate S-interface transceiver inside its 20-frame multiframe. For each frame it produces the values of three overhead bits:

- the auxiliary framing bit (FA),
- the multiframe marker bit (M),
- the S-channel bit (S).

It also serves one shared sync pin. One single-cycle strobe at the start of each F-bit marks a new frame. The counter moves on that strobe. The overhead values for the new frame appear one clock later.

The block works in one of two modes. In master (network-side) mode the sync pin is an input. It is sampled once per frame, on the F-bit strobe. While it reads high, the counter is held at its last frame and all overhead bits are blanked. The first frame that samples low restarts the multiframe at frame 1. Several transceivers that share one sync line therefore share one multiframe alignment, whatever the length of the sync pulse. In slave (terminal-side) mode the pin is an output. It carries the received M-bit, captured on each rising edge of the frame sync clock, so the value is steady when the next falling edge samples it. Line polarity, line coding and frame detection are handled elsewhere.

Top module: `mfsync_top`

## Requirements
- R1: Each F-bit strobe advances the frame number by one, through 1 to 20, and from 20 it wraps to 1 without outside help. Between strobes the frame number does not change.
- R2: While running, FA is 1 in frames 1, 6, 11 and 16 (frame minus one divisible by 5) and 0 in the other frames. M is 1 only in frame 1.
- R3: While running, S equals bit ((frame − 1) mod 5) of the 5-bit `s_word` input, where bit 0 is the least significant.
- R4: While `mf_en` is 0, FA, M and S are 0 and `ovh_blank` is 1 at once. The next strobe parks the frame number at 20.
- R5: In master mode with `pin_sel` set, a strobe that samples the sync pin at 1 sets the frame number to 20 and blanks FA, M and S (`ovh_blank` = 1). The state holds for as long as the pin keeps sampling 1.
- R6: The first strobe that samples 0 after a hold or a park starts frame 1, with FA = 1 and M = 1. Counting then continues normally.
- R7: With `pin_sel` clear, the sync pin has no effect on the counter and `sync_pin_oe` is 0.
- R8: In slave mode with `pin_sel` set, `sync_pin_oe` is 1. `sync_pin_out` takes the value of `mbit_rx` after each rising edge of `fsc` and keeps it until the next rising edge. The sync pin input is ignored.
- R9: Synchronous active-low reset sets the frame number to 20, sets `ovh_blank` and drives `sync_pin_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fbit_stb | input | 1 | One-cycle strobe at the start of each frame's F-bit |
| fsc | input | 1 | Frame sync clock (slave-mode output timing) |
| master_mode | input | 1 | 1 = master (network side), 0 = slave (terminal side) |
| mf_en | input | 1 | Multiframe generation enable |
| pin_sel | input | 1 | Gives the shared pin its sync function |
| s_word | input | SBITS | S-channel word, indexed by frame position |
| mbit_rx | input | 1 | Received M-bit (slave mode) |
| sync_pin_in | input | 1 | Sync pin input level |
| sync_pin_out | output | 1 | Sync pin output level |
| sync_pin_oe | output | 1 | Sync pin output enable |
| frame_num | output | CW | Current frame number, 1 to FRAMES |
| fa_bit | output | 1 | FA overhead value, 1 = mark |
| m_bit | output | 1 | M overhead value, 1 = mark |
| s_bit | output | 1 | S overhead value, 1 = mark |
| ovh_blank | output | 1 | Overhead is forced to logic zero (held or disabled) |

## Verification
The bench builds the block with its default parameters: 20 frames, a 5-bit S word and an FA spacing of 5. With these values, one table walk of 27 frames crosses the 20-to-1 wrap, reaches every FA position and every S-word bit, and includes a three-frame hold followed by a restart. Directed tests then cover the disable park, the pin-select gating, slave-mode M-bit capture on the rising edge of the frame sync clock, and a reset applied in mid-run.

// File: rtl/mf_pkg.sv
// Package: shared mode type for the multiframe sync block.
// Assumes: one mode bit, 1 = master (network side), 0 = slave (terminal side).
package mf_pkg;
    typedef enum logic {
        MODE_SLAVE  = 1'b0,
        MODE_MASTER = 1'b1
    } mf_mode_e;
endpackage

// File: rtl/mf_counter.sv
// Module: multiframe frame counter.
// Moves once per F-bit strobe through 1..FRAMES and wraps. A hold request or a
// cleared enable parks it at FRAMES with the held flag set.
// Assumes: fbit_stb is a single-cycle pulse; hold_req is already qualified.
module mf_counter #(
    parameter int FRAMES = 20,
    parameter int CW     = $clog2(FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fbit_stb,
    input  logic          mf_en,
    input  logic          hold_req,
    output logic [CW-1:0] cnt,
    output logic          held
);
    localparam logic [CW-1:0] LAST  = CW'(FRAMES);
    localparam logic [CW-1:0] FIRST = CW'(1);

    // Frame position register: park, wrap or step on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= LAST;
            held <= 1'b1;
        end else if (fbit_stb) begin
            if (!mf_en || hold_req) begin
                cnt  <= LAST;
                held <= 1'b1;
            end else begin
                held <= 1'b0;
                cnt  <= (cnt == LAST) ? FIRST : cnt + FIRST;
            end
        end
    end

    assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= FIRST) && (cnt <= LAST));
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_stb && mf_en && !hold_req && (cnt == LAST) |=> (cnt == FIRST) && !held);
    assert_still_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fbit_stb |=> $stable(cnt) && $stable(held));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_stb && hold_req |=> (cnt == LAST) && held);
    assert_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_stb && !mf_en |=> (cnt == LAST) && held);
endmodule

// File: rtl/mf_overhead.sv
// Module: overhead bit values for the current frame.
// FA marks every FA_STEP-th frame starting at frame 1, M marks frame 1, and S
// picks one bit of the S word by frame position. All are forced low when blanked.
// Assumes: cnt stays in 1..FRAMES; clk and rst_n are used only by assertions.
module mf_overhead #(
    parameter int FRAMES  = 20,
    parameter int SBITS   = 5,
    parameter int FA_STEP = 5,
    parameter int CW      = $clog2(FRAMES + 1),
    parameter int SW      = (SBITS > 1) ? $clog2(SBITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cnt,
    input  logic             held,
    input  logic             mf_en,
    input  logic [SBITS-1:0] s_word,
    output logic             fa_bit,
    output logic             m_bit,
    output logic             s_bit,
    output logic             blank
);
    logic [CW-1:0] pos;
    logic [SW-1:0] sidx;
    logic          active;

    // Decode the frame position into the three overhead values.
    always_comb begin
        active = mf_en && !held;
        blank  = !active;
        pos    = cnt - CW'(1);
        sidx   = SW'(pos % CW'(SBITS));
        fa_bit = active && ((pos % CW'(FA_STEP)) == '0);
        m_bit  = active && (pos == '0);
        s_bit  = active && s_word[sidx];
    end

    assert_m_frame1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m_bit |-> fa_bit && (cnt == CW'(1)));
    assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !fa_bit && !m_bit && !s_bit);
    assert_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_en |-> blank);
endmodule

// File: rtl/mf_pin.sv
// Module: shared sync pin control.
// Master mode: qualifies the pin input as a hold request. Slave mode: drives the
// received M-bit, captured on each rising edge of fsc, so it is steady at the falling edge.
// Assumes: fsc is much slower than clk; it is synchronized here.
module mf_pin
    import mf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic pin_sel,
    input  logic fsc,
    input  logic mbit_rx,
    input  logic pin_in,
    output logic hold_req,
    output logic pin_out,
    output logic pin_oe
);
    mf_mode_e mode;
    logic [2:0] fsc_sync;
    logic       fsc_rise;

    assign mode     = mf_mode_e'(master_mode);
    assign hold_req = (mode == MODE_MASTER) && pin_sel && pin_in;
    assign pin_oe   = (mode == MODE_SLAVE) && pin_sel;
    assign fsc_rise = fsc_sync[1] && !fsc_sync[2];

    // Synchronize fsc and keep a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fsc_sync <= '0;
        else        fsc_sync <= {fsc_sync[1:0], fsc};
    end

    // Capture the received M-bit on each rising fsc edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        pin_out <= 1'b0;
        else if (fsc_rise) pin_out <= mbit_rx;
    end

    assert_oe_slave_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> !master_mode && pin_sel);
    assert_out_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fsc_rise |=> $stable(pin_out));
    assert_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_sel |-> !hold_req && !pin_oe);
endmodule

// File: rtl/mfsync_top.sv
// Module: S-interface multiframe sync counter, top level.
// Connects the frame counter, the overhead decoder and the shared sync pin.
// Assumes: one fbit_stb pulse per frame; the pin's tristate is resolved outside.
module mfsync_top #(
    parameter int FRAMES  = 20,
    parameter int SBITS   = 5,
    parameter int FA_STEP = 5,
    localparam int CW     = $clog2(FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fbit_stb,
    input  logic             fsc,
    input  logic             master_mode,
    input  logic             mf_en,
    input  logic             pin_sel,
    input  logic [SBITS-1:0] s_word,
    input  logic             mbit_rx,
    input  logic             sync_pin_in,
    output logic             sync_pin_out,
    output logic             sync_pin_oe,
    output logic [CW-1:0]    frame_num,
    output logic             fa_bit,
    output logic             m_bit,
    output logic             s_bit,
    output logic             ovh_blank
);
    logic hold_req;
    logic held;

    mf_pin u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .pin_sel     (pin_sel),
        .fsc         (fsc),
        .mbit_rx     (mbit_rx),
        .pin_in      (sync_pin_in),
        .hold_req    (hold_req),
        .pin_out     (sync_pin_out),
        .pin_oe      (sync_pin_oe)
    );

    mf_counter #(.FRAMES(FRAMES), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fbit_stb (fbit_stb),
        .mf_en    (mf_en),
        .hold_req (hold_req),
        .cnt      (frame_num),
        .held     (held)
    );

    mf_overhead #(.FRAMES(FRAMES), .SBITS(SBITS), .FA_STEP(FA_STEP), .CW(CW)) u_ovh (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (frame_num),
        .held   (held),
        .mf_en  (mf_en),
        .s_word (s_word),
        .fa_bit (fa_bit),
        .m_bit  (m_bit),
        .s_bit  (s_bit),
        .blank  (ovh_blank)
    );

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_stb && mf_en && !hold_req && ovh_blank |=> (frame_num == CW'(1)) && fa_bit && m_bit);
endmodule

// File: tb/mfsync_top_tb.sv
// Bench for mfsync_top: a table walk in master mode, then directed tests.
module mfsync_top_tb;
    localparam int FRAMES = 20;
    localparam int SBITS  = 5;
    localparam int CW     = $clog2(FRAMES + 1);
    localparam logic [SBITS-1:0] SW_VAL = 5'b10110;
    localparam int NVEC = 27;
    // Each entry: {sync pin level, expected frame number after the strobe}.
    localparam logic [5:0] VEC [NVEC] = '{
        6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9, 6'd10,
        6'd11, 6'd12, 6'd13, 6'd14, 6'd15, 6'd16, 6'd17, 6'd18, 6'd19, 6'd20,
        6'd1, 6'd2, {1'b1, 5'd20}, {1'b1, 5'd20}, {1'b1, 5'd20}, 6'd1, 6'd2
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fbit_stb = 1'b0, fsc = 1'b0, master_mode = 1'b1, mf_en = 1'b1, pin_sel = 1'b1;
    logic [SBITS-1:0] s_word = SW_VAL;
    logic mbit_rx = 1'b0, sync_pin_in = 1'b0;
    logic sync_pin_out, sync_pin_oe, fa_bit, m_bit, s_bit, ovh_blank;
    logic [CW-1:0] frame_num;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    mfsync_top #(.FRAMES(FRAMES), .SBITS(SBITS), .FA_STEP(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .fbit_stb(fbit_stb), .fsc(fsc),
        .master_mode(master_mode), .mf_en(mf_en), .pin_sel(pin_sel),
        .s_word(s_word), .mbit_rx(mbit_rx), .sync_pin_in(sync_pin_in),
        .sync_pin_out(sync_pin_out), .sync_pin_oe(sync_pin_oe),
        .frame_num(frame_num), .fa_bit(fa_bit), .m_bit(m_bit),
        .s_bit(s_bit), .ovh_blank(ovh_blank)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One F-bit strobe; outputs are settled at the following negedge.
    task automatic strobe();
        @(negedge clk) fbit_stb = 1'b1;
        @(negedge clk) fbit_stb = 1'b0;
    endtask

    task automatic pulse_fsc();
        @(negedge clk) fsc = 1'b1;
        repeat (5) @(negedge clk);
        fsc = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Expected overhead for a running frame f, from R2 and R3.
    task automatic chk_frame(input string req, input int f, input bit blank);
        chk({req, " frame"}, int'(frame_num), f);
        chk({req, " blank"}, int'(ovh_blank), int'(blank));
        chk({req, " FA R2"}, int'(fa_bit), int'(!blank && ((f - 1) % 5 == 0)));
        chk({req, " M R2"}, int'(m_bit), int'(!blank && f == 1));
        chk({req, " S R3"}, int'(s_bit), int'(!blank && SW_VAL[(f - 1) % 5]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 frame", int'(frame_num), FRAMES);
        chk("R9 blank", int'(ovh_blank), 1);
        chk("R9 pin", int'(sync_pin_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 counting and wrap, R5 hold, R6 restart
        for (int i = 0; i < NVEC; i++) begin
            sync_pin_in = VEC[i][5];
            strobe();
            chk_frame(VEC[i][5] ? "R5 hold" : "R1 step", int'(VEC[i][4:0]), VEC[i][5]);
        end
        sync_pin_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 steady between strobes", int'(frame_num), 2);

        // R4: disable blanks at once, parks at 20 on the next strobe
        mf_en = 1'b0;
        @(negedge clk);
        chk("R4 blank immediate", int'(ovh_blank), 1);
        chk("R4 FA zero", int'(fa_bit), 0);
        strobe();
        chk_frame("R4 parked", FRAMES, 1'b1);
        mf_en = 1'b1;
        strobe();
        chk_frame("R6 restart after park", 1, 1'b0);

        // R7: pin_sel clear, sync pin ignored
        pin_sel = 1'b0;
        sync_pin_in = 1'b1;
        strobe();
        chk_frame("R7 pin ignored", 2, 1'b0);
        chk("R7 oe", int'(sync_pin_oe), 0);

        // R8: slave mode
        master_mode = 1'b0;
        pin_sel = 1'b1;
        @(negedge clk);
        chk("R8 oe", int'(sync_pin_oe), 1);
        strobe();
        chk_frame("R8 sync ignored in slave", 3, 1'b0);
        mbit_rx = 1'b1;
        pulse_fsc();
        chk("R8 captured 1", int'(sync_pin_out), 1);
        mbit_rx = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 held without fsc edge", int'(sync_pin_out), 1);
        pulse_fsc();
        chk("R8 captured 0", int'(sync_pin_out), 0);
        mbit_rx = 1'b1;
        pulse_fsc();

        // R9: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid frame", int'(frame_num), FRAMES);
        chk("R9 mid blank", int'(ovh_blank), 1);
        chk("R9 mid pin", int'(sync_pin_out), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule